// File: doc/BRIEF.md
# Sector Erase Timing Controller

This block schedules the timing of sector and chip erases inside a parallel NOR flash model. A sector-erase command marks one sector as erasing and opens a short acceptance window. While that window is open, more sector-erase commands can be added, and each one restarts the window. When the window closes, a timed erase runs. Its length is a per-sector erase time multiplied by the number of distinct sectors queued. When the erase timer runs out, the queue empties and the device returns to read mode.

An erase can be suspended and resumed. A suspend during the window saves the full computed erase time. A suspend during the erase saves the exact number of ticks still left. A resume loads the saved value into the timer and continues the erase. While the erase is suspended, new erase commands are rejected, and the block refuses programs that target a sector still marked as erasing. A chip erase runs for its own fixed time, and every command is ignored until it ends.

All time is counted in ticks of a periodic enable input, and the durations are parameters given in microseconds and milliseconds. The data path and the clearing of the array are not part of this block.

Top module: `sect_erase_ctl`

## Requirements
- R1: After reset, `dq3`, `erase_busy`, `chip_busy` and `suspended` are 0, and `erasing_map`, `sector_count` and `remain_ticks` are all zero.
- R2: A sector-erase command in read mode or during the acceptance window has these effects: it sets bit `cmd_sector` of `erasing_map`, it raises `sector_count` by one only when that bit was clear, it clears `dq3`, and it reloads the window to ACCEPT_US*TICKS_PER_US ticks.
- R3: When the window counts down on its last tick with no command in that cycle, `dq3` rises. An erase of `sector_count`*2^SECT_EXP*US_PER_MS*TICKS_PER_US ticks then starts.
- R4: When the erase timer expires, `erasing_map` and `sector_count` clear, `dq3` falls and `erase_busy` falls.
- R5: During the window, any other command aborts to read mode and clears the map and the count. During a running erase, other commands and sector-erase commands have no effect.
- R6: A suspend during the window sets `remain_ticks` to the full erase time for the queued count, raises `suspended`, drops `erase_busy`, and stops the timer.
- R7: A suspend during a running erase sets `remain_ticks` to the ticks still left on the timer, which is never below 1.
- R8: A resume while suspended restarts the erase with `remain_ticks` ticks, clears `remain_ticks` and sets `dq3`. A suspend or resume in read mode has no effect.
- R9: While suspended, sector-erase and chip-erase commands are rejected and the map is left unchanged. `prog_grant` is 0 for a sector whose map bit is set and 1 for any other sector.
- R10: A chip erase from read mode keeps `chip_busy` and `erase_busy` high for 2^CHIP_EXP*US_PER_MS*TICKS_PER_US ticks. All commands are ignored during that time.
- R11: `prog_grant` follows `prog_req` in read mode. It is 0 while the window, an erase or a chip erase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Periodic time-base enable, TICKS_PER_US per microsecond |
| cmd_sec_erase | input | 1 | Sector-erase command strobe |
| cmd_sector | input | SECT_W | Sector index for the sector-erase command |
| cmd_chip_erase | input | 1 | Chip-erase command strobe |
| cmd_suspend | input | 1 | Erase-suspend strobe |
| cmd_resume | input | 1 | Erase-resume strobe |
| cmd_other | input | 1 | Any other command write |
| prog_req | input | 1 | Program request |
| prog_sector | input | SECT_W | Sector targeted by the program request |
| prog_grant | output | 1 | Program may proceed (combinational) |
| dq3 | output | 1 | Erase-timer status bit: 0 while commands are accepted, 1 once the erase runs |
| erase_busy | output | 1 | Window, sector erase or chip erase in progress |
| chip_busy | output | 1 | Chip erase in progress |
| suspended | output | 1 | Sector erase suspended |
| erasing_map | output | NSECT | One bit per sector queued for erase |
| sector_count | output | CNT_W | Number of distinct queued sectors |
| remain_ticks | output | TIME_W | Saved erase time while suspended |

## Verification
The bench builds the block with 8 sectors, 2 ticks per microsecond, 3 microseconds per millisecond, a 2-microsecond window, a sector exponent of 1 and a chip exponent of 2. With these values the window lasts 4 ticks, each sector adds 12 ticks, and a chip erase lasts 24 ticks. Because the tick enable fires only every third clock, the full window, erase, suspend-mid-countdown and chip-erase paths all fit in a few hundred cycles. The narrow sector index also lets duplicate sectors, map-blocked programs and every map bit be exercised directly.

// File: rtl/sect_erase_pkg.sv
package sect_erase_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WINDOW = 3'd1,
      ST_ERASE  = 3'd2,
      ST_SUSP   = 3'd3,
      ST_CHIP   = 3'd4
   } se_state_t;
endpackage

// File: rtl/set_countdown.sv
module set_countdown #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic [W-1:0] value,
   output logic         expire
);
   assign expire = run && (value == W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= '0;
      else if (load) value <= load_val;
      else if (run)  value <= value - W'(1);
   end

   // R3: a running timer never counts from zero
   a_r3_timer_live: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (value != '0));
endmodule

// File: rtl/set_sector_map.sv
module set_sector_map #(
   parameter int unsigned NSECT  = 16,
   parameter int unsigned SECT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [SECT_W-1:0] set_idx,
   input  logic              clr,
   input  logic [SECT_W-1:0] query_idx,
   output logic [NSECT-1:0]  map,
   output logic              set_new,
   output logic              query_hit
);
   genvar i;
   generate
      for (i = 0; i < NSECT; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)                            map[i] <= 1'b0;
            else if (clr)                          map[i] <= 1'b0;
            else if (set_en && set_idx == SECT_W'(i)) map[i] <= 1'b1;
         end
      end
   endgenerate

   assign set_new   = !map[set_idx];
   assign query_hit = map[query_idx];

   // R2: a set request leaves that sector marked on the next cycle
   a_r2_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr) |=> map[$past(set_idx)]);
endmodule

// File: rtl/set_duration.sv
module set_duration #(
   parameter int unsigned     CNT_W  = 5,
   parameter int unsigned     TIME_W = 23,
   parameter longint unsigned UNIT_T = 512000
) (
   input  logic [CNT_W-1:0]  count,
   output logic [TIME_W-1:0] ticks
);
   localparam logic [TIME_W-1:0] UNIT_V = TIME_W'(UNIT_T);
   assign ticks = TIME_W'(count) * UNIT_V;
endmodule

// File: rtl/sect_erase_ctl.sv
module sect_erase_ctl
   import sect_erase_pkg::*;
#(
   parameter int unsigned NSECT        = 16,
   parameter int unsigned TICKS_PER_US = 1,
   parameter int unsigned US_PER_MS    = 1000,
   parameter int unsigned ACCEPT_US    = 50,
   parameter int unsigned SECT_EXP     = 9,
   parameter int unsigned CHIP_EXP     = 12,
   localparam int unsigned SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1,
   localparam int unsigned CNT_W  = $clog2(NSECT + 1),
   localparam longint unsigned ACC_T  = longint'(ACCEPT_US) * TICKS_PER_US,
   localparam longint unsigned UNIT_T = (64'd1 << SECT_EXP) * US_PER_MS * TICKS_PER_US,
   localparam longint unsigned CHIP_T = (64'd1 << CHIP_EXP) * US_PER_MS * TICKS_PER_US,
   localparam longint unsigned SECT_MAX = UNIT_T * NSECT,
   localparam longint unsigned MAX_A  = (SECT_MAX > CHIP_T) ? SECT_MAX : CHIP_T,
   localparam longint unsigned MAX_T  = (MAX_A > ACC_T) ? MAX_A : ACC_T,
   localparam int unsigned TIME_W = $clog2(MAX_T + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cmd_sec_erase,
   input  logic [SECT_W-1:0] cmd_sector,
   input  logic              cmd_chip_erase,
   input  logic              cmd_suspend,
   input  logic              cmd_resume,
   input  logic              cmd_other,
   input  logic              prog_req,
   input  logic [SECT_W-1:0] prog_sector,
   output logic              prog_grant,
   output logic              dq3,
   output logic              erase_busy,
   output logic              chip_busy,
   output logic              suspended,
   output logic [NSECT-1:0]  erasing_map,
   output logic [CNT_W-1:0]  sector_count,
   output logic [TIME_W-1:0] remain_ticks
);
   generate
      if (NSECT < 2 || (1 << SECT_W) != NSECT) begin : g_bad_nsect
         $error("NSECT must be a power of two of at least 2");
      end
      if (TICKS_PER_US == 0 || US_PER_MS == 0 || ACCEPT_US == 0) begin : g_bad_time
         $error("time parameters must be nonzero");
      end
      if (SECT_EXP > 30 || CHIP_EXP > 30) begin : g_bad_exp
         $error("erase exponents out of range");
      end
   endgenerate

   se_state_t         st;
   logic [TIME_W-1:0] tmr_val, tmr_load_val, full_ticks;
   logic              tmr_load, tmr_run, tmr_exp;
   logic              set_new, prog_hit;
   logic              ev_sec, ev_susp_w, ev_susp_e, ev_resume, ev_chip, ev_abort, any_ev;
   logic              active, done_erase, map_clr;

   // command decode, first match wins
   always_comb begin
      ev_sec    = cmd_sec_erase && (st == ST_IDLE || st == ST_WINDOW);
      ev_susp_w = !ev_sec && cmd_suspend && st == ST_WINDOW;
      ev_susp_e = cmd_suspend && st == ST_ERASE;
      ev_resume = cmd_resume && st == ST_SUSP;
      ev_chip   = !ev_sec && cmd_chip_erase && st == ST_IDLE;
      ev_abort  = !ev_sec && !ev_susp_w && cmd_other && st == ST_WINDOW;
      any_ev    = ev_sec | ev_susp_w | ev_susp_e | ev_resume | ev_chip | ev_abort;
      active    = (st == ST_WINDOW) || (st == ST_ERASE) || (st == ST_CHIP);
      tmr_run   = tick && active && !any_ev;
      done_erase = tmr_exp && st == ST_ERASE;
      map_clr   = ev_abort || done_erase;
   end

   always_comb begin
      tmr_load     = 1'b1;
      tmr_load_val = '0;
      if (ev_sec)                          tmr_load_val = TIME_W'(ACC_T);
      else if (ev_resume)                  tmr_load_val = remain_ticks;
      else if (ev_chip)                    tmr_load_val = TIME_W'(CHIP_T);
      else if (tmr_exp && st == ST_WINDOW) tmr_load_val = full_ticks;
      else                                 tmr_load = 1'b0;
   end

   set_countdown #(.W(TIME_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_load_val),
      .run(tmr_run), .value(tmr_val), .expire(tmr_exp));

   set_sector_map #(.NSECT(NSECT), .SECT_W(SECT_W)) u_map (
      .clk(clk), .rst_n(rst_n), .set_en(ev_sec), .set_idx(cmd_sector),
      .clr(map_clr), .query_idx(prog_sector), .map(erasing_map),
      .set_new(set_new), .query_hit(prog_hit));

   set_duration #(.CNT_W(CNT_W), .TIME_W(TIME_W), .UNIT_T(UNIT_T)) u_dur (
      .count(sector_count), .ticks(full_ticks));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         dq3          <= 1'b0;
         sector_count <= '0;
         remain_ticks <= '0;
      end else if (ev_sec) begin
         st  <= ST_WINDOW;
         dq3 <= 1'b0;
         if (set_new) sector_count <= sector_count + CNT_W'(1);
      end else if (ev_susp_w) begin
         st           <= ST_SUSP;
         remain_ticks <= full_ticks;
      end else if (ev_susp_e) begin
         st           <= ST_SUSP;
         remain_ticks <= (tmr_val == '0) ? TIME_W'(1) : tmr_val;
      end else if (ev_resume) begin
         st           <= ST_ERASE;
         dq3          <= 1'b1;
         remain_ticks <= '0;
      end else if (ev_chip) begin
         st <= ST_CHIP;
      end else if (ev_abort) begin
         st           <= ST_IDLE;
         dq3          <= 1'b0;
         sector_count <= '0;
      end else if (tmr_exp) begin
         case (st)
            ST_WINDOW: begin st <= ST_ERASE; dq3 <= 1'b1; end
            ST_ERASE:  begin st <= ST_IDLE; dq3 <= 1'b0; sector_count <= '0; end
            default:   st <= ST_IDLE;
         endcase
      end
   end

   assign erase_busy = active;
   assign chip_busy  = (st == ST_CHIP);
   assign suspended  = (st == ST_SUSP);
   assign prog_grant = prog_req && ((st == ST_IDLE) || (st == ST_SUSP && !prog_hit));

   a_r3_dq3_low_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WINDOW) |-> !dq3);
   a_r2_count_tracks_map: assert property (@(posedge clk) disable iff (!rst_n)
      sector_count == CNT_W'($countones(erasing_map)));
   a_r4_idle_map_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (erasing_map == '0));
   a_r7_remain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SUSP) |-> (remain_ticks != '0));
   a_r8_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ev_resume |=> (remain_ticks == '0 && dq3 && erase_busy));
   a_r9_no_grant_erasing: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_grant && suspended) |-> !erasing_map[prog_sector]);
endmodule

// File: tb/sect_erase_ctl_tb.sv
`timescale 1ns/1ps
module sect_erase_ctl_tb;
   localparam int NS = 8, TPU = 2, UPM = 3, ACC = 2, SE = 1, CE = 2;
   localparam int ACC_T = ACC * TPU;
   localparam int UNIT  = (1 << SE) * UPM * TPU;
   localparam int CHIPT = (1 << CE) * UPM * TPU;
   localparam int SW = 3, CW = 4, TW = 7;

   logic clk = 0, rst_n = 0, tick = 0;
   logic cs = 0, cc = 0, csp = 0, crs = 0, co = 0, pr = 0;
   logic [SW-1:0] csec = '0, psec = '0;
   logic pg, dq3, busy, cbusy, susp;
   logic [NS-1:0] map;
   logic [CW-1:0] cnt;
   logic [TW-1:0] rem;

   always #4 clk = ~clk;

   sect_erase_ctl #(.NSECT(NS), .TICKS_PER_US(TPU), .US_PER_MS(UPM),
      .ACCEPT_US(ACC), .SECT_EXP(SE), .CHIP_EXP(CE)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_sec_erase(cs), .cmd_sector(csec),
      .cmd_chip_erase(cc), .cmd_suspend(csp), .cmd_resume(crs), .cmd_other(co),
      .prog_req(pr), .prog_sector(psec), .prog_grant(pg), .dq3(dq3),
      .erase_busy(busy), .chip_busy(cbusy), .suspended(susp), .erasing_map(map),
      .sector_count(cnt), .remain_ticks(rem));

   int total = 0, fails = 0;
   bit finished = 0;

   task automatic check(string req, longint act, longint exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference: 0 idle, 1 window, 2 erase, 3 suspended, 4 chip
   int ms = 0, mt = 0, mrem = 0, mcnt = 0;
   bit mdq3 = 0;
   bit [NS-1:0] mmap = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mt = 0; mrem = 0; mcnt = 0; mdq3 = 0; mmap = '0;
      end else if (cs && (ms == 0 || ms == 1)) begin
         if (!mmap[csec]) begin mmap[csec] = 1; mcnt++; end
         mdq3 = 0; mt = ACC_T; ms = 1;
      end else if (csp && ms == 1) begin
         mrem = mcnt * UNIT; ms = 3;
      end else if (csp && ms == 2) begin
         mrem = mt; ms = 3;
      end else if (crs && ms == 3) begin
         mt = mrem; mrem = 0; mdq3 = 1; ms = 2;
      end else if (cc && ms == 0) begin
         mt = CHIPT; ms = 4;
      end else if (co && ms == 1) begin
         mmap = '0; mcnt = 0; mdq3 = 0; ms = 0;
      end else if (tick && (ms == 1 || ms == 2 || ms == 4)) begin
         if (mt == 1) begin
            if (ms == 1) begin mdq3 = 1; mt = mcnt * UNIT; ms = 2; end
            else if (ms == 2) begin mmap = '0; mcnt = 0; mdq3 = 0; ms = 0; end
            else ms = 0;
         end else mt--;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R3 dq3", dq3, mdq3);
         check("R2 busy", busy, (ms == 1 || ms == 2 || ms == 4));
         check("R10 chip_busy", cbusy, ms == 4);
         check("R6 suspended", susp, ms == 3);
         check("R2 map", map, mmap);
         check("R2 count", cnt, mcnt);
         check("R7 remain", rem, mrem);
         check("R11 grant", pg, pr && (ms == 0 || (ms == 3 && !mmap[psec])));
      end
   end

   initial begin
      int ph = 0;
      forever begin
         @(posedge clk); #1;
         tick = (ph == 2);
         ph = (ph + 1) % 3;
      end
   end

   task automatic pulse(int kind, int s);
      @(posedge clk); #2;
      csec = SW'(s);
      case (kind)
         0: cs = 1; 1: cc = 1; 2: csp = 1; 3: crs = 1; default: co = 1;
      endcase
      @(posedge clk); #2;
      cs = 0; cc = 0; csp = 0; crs = 0; co = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && (busy || susp); i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_dq3();
      for (int i = 0; i < 2000 && !dq3; i++) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 dq3", dq3, 0); check("R1 busy", busy, 0);
      check("R1 map", map, 0); check("R1 remain", rem, 0);
      #1 rst_n = 1;

      // R2 queue with duplicate
      pulse(0, 2); pulse(0, 5); pulse(0, 5);
      @(negedge clk);
      check("R2 count after duplicate", cnt, 2);
      check("R2 map bits", map, 8'h24);
      wait_dq3();
      check("R3 dq3 high after window", dq3, 1);
      wait_idle();
      check("R4 map cleared", map, 0);
      check("R4 count cleared", cnt, 0);

      // R5 abort in window
      pulse(0, 1); pulse(4, 0);
      @(negedge clk);
      check("R5 abort busy", busy, 0);
      check("R5 abort map", map, 0);

      // R5/R7/R9/R8 erase with suspend
      pulse(0, 3); pulse(0, 4);
      wait_dq3();
      pulse(0, 6); pulse(4, 0);
      @(negedge clk);
      check("R5 ignored during erase", map, 8'h18);
      repeat (10) @(posedge clk);
      pulse(2, 0);
      @(negedge clk);
      check("R7 suspended", susp, 1);
      check("R7 remain in range", (rem >= 1 && rem < 2 * UNIT), 1);
      pr = 1; psec = 3;
      @(negedge clk);
      check("R9 grant blocked sector", pg, 0);
      psec = 0;
      @(negedge clk);
      check("R9 grant other sector", pg, 1);
      pr = 0;
      pulse(0, 7); pulse(1, 0);
      @(negedge clk);
      check("R9 map unchanged", map, 8'h18);
      check("R9 chip rejected", cbusy, 0);
      pulse(3, 0);
      @(negedge clk);
      check("R8 remain cleared", rem, 0);
      check("R8 dq3 set", dq3, 1);
      wait_idle();

      // R6 suspend in window
      pulse(0, 7); pulse(2, 0);
      @(negedge clk);
      check("R6 full time saved", rem, UNIT);
      check("R6 busy low", busy, 0);
      pulse(3, 0);
      wait_idle();

      // R8 ignored in idle
      pulse(2, 0); pulse(3, 0);
      @(negedge clk);
      check("R8 idle suspend ignored", susp, 0);
      check("R8 idle remain", rem, 0);

      // R10/R11 chip erase
      pr = 1; psec = 1;
      @(negedge clk);
      check("R11 grant in idle", pg, 1);
      pulse(1, 0);
      @(negedge clk);
      check("R10 chip busy", cbusy, 1);
      check("R11 grant blocked", pg, 0);
      pulse(0, 2); pulse(2, 0);
      @(negedge clk);
      check("R10 commands ignored", map, 0);
      pr = 0;
      wait_idle();
      check("R10 chip done", cbusy, 0);

      repeat (5) @(posedge clk);
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule